// File: doc/BRIEF.md
# GPIO Interrupt Event Controller

A 32-pin general-purpose I/O block with a single-cycle register port. Each input pin is passed through a two-flop synchroniser. The synchronised level is then compared with its value from the previous cycle to find edges. A 2-bit kind field per pin picks the condition that raises an event: both edges, rising only, falling only, or a low level. Events are held in a sticky event register, and software clears them by writing ones. A mask register gates the events onto one combined interrupt line.

The kind fields are split across two registers. Pins 0 to 15 use the low control word and pins 16 to 31 use the high one. Within each half the fields are packed from the top down, so the lowest-numbered pin of a half owns the two most significant bits. The block also has simple direction and output-data registers that drive the pad enables and pad outputs directly.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `gpio_o` and `gpio_oe_o` are 0.
- R2: The registers read back exactly what was written: direction at 0x00 (driven on `gpio_oe_o`), output data at 0x04 (driven on `gpio_o`), mask at 0x10, low kind word at 0x14 and high kind word at 0x18. Any unmapped offset reads 0.
- R3: Offset 0x08 returns the pin levels after the two-flop synchroniser. A pin change shows there on the second rising clock edge after it.
- R4: Pin p < 16 takes its kind from bits [(15-p)*2+1:(15-p)*2] of 0x14. Pin p >= 16 takes it from bits [(31-p)*2+1:(31-p)*2] of 0x18.
- R5: Kind 2'b00 raises an event on both rising and falling edges.
- R6: Kind 2'b01 raises an event on rising edges only, and kind 2'b10 on falling edges only.
- R7: Kind 2'b11 raises an event while the synchronised pin is low. While the pin stays low the event bit stays set and a clear has no lasting effect.
- R8: The event register at 0x0C is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: If an event arrives in the same cycle as a clear of that bit, the bit ends set.
- R10: `irq_o` is high exactly when some event bit and its mask bit (0x10) are both 1.
- R11: An edge at a pin sets its event bit on the third rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| gpio_i | input | 32 | Pin input levels, asynchronous |
| gpio_o | output | 32 | Pin output data |
| gpio_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that `gpio_i` is quiet during reset: a pin held high through reset would show a rising edge once reset releases. The bench therefore holds every pin low until reset is released. The assertions also assume that a kind field changes only through a register write. The bench changes pins and kind words only at falling clock edges and lets the synchroniser settle between steps. The same-cycle clear-versus-event case is driven by placing the clear write in the cycle where the detector fires.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    EVT_BOTH = 2'b00,
    EVT_RISE = 2'b01,
    EVT_FALL = 2'b10,
    EVT_LOW  = 2'b11
  } evt_kind_e;

  localparam int unsigned OFS_DIR    = 'h00;
  localparam int unsigned OFS_DOUT   = 'h04;
  localparam int unsigned OFS_PIN    = 'h08;
  localparam int unsigned OFS_EVT    = 'h0C;
  localparam int unsigned OFS_MASK   = 'h10;
  localparam int unsigned OFS_KIND_L = 'h14;
  localparam int unsigned OFS_KIND_H = 'h18;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect import gpio_evt_pkg::*; #(
  parameter int unsigned NPIN = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic      [NPIN-1:0] pin_s_i,
  input  evt_kind_e [NPIN-1:0] kind_i,
  input  logic      [NPIN-1:0] clr_i,
  output logic      [NPIN-1:0] evt_o
);
  logic [NPIN-1:0] prev_q, hit, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_s_i;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise, fall, hit_p;
    assign rise = pin_s_i[p] & ~prev_q[p];
    assign fall = ~pin_s_i[p] & prev_q[p];

    always_comb begin
      case (kind_i[p])
        EVT_BOTH: hit_p = rise | fall;
        EVT_RISE: hit_p = rise;
        EVT_FALL: hit_p = fall;
        EVT_LOW:  hit_p = ~pin_s_i[p];
        default:  hit_p = 1'b0;
      endcase
    end
    assign hit[p] = hit_p;

    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[p] && !hit_p) |=> !evt_q[p]); // R8
    AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_q[p] && !clr_i[p]) |=> evt_q[p]); // R8
    AST_HIT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[p] && hit_p) |=> evt_q[p]); // R9
    AST_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i[p] == EVT_LOW && !pin_s_i[p]) |=> evt_q[p]); // R7
    AST_RISE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i[p] == EVT_RISE && !evt_q[p] && !(pin_s_i[p] && !prev_q[p])) |=> !evt_q[p]); // R6
  end

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i) | hit;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs import gpio_evt_pkg::*; #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   evt_i,
  input  logic [NPIN-1:0]   pin_s_i,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   dout_o,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   kind_l_o,
  output logic [NPIN-1:0]   kind_h_o,
  output logic [NPIN-1:0]   clr_o
);
  logic [NPIN-1:0] dir_q, dout_q, mask_q, kind_l_q, kind_h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      dout_q   <= '0;
      mask_q   <= '0;
      kind_l_q <= '0;
      kind_h_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(OFS_DIR))    dir_q    <= wdata_i;
      if (addr_i == ADDR_W'(OFS_DOUT))   dout_q   <= wdata_i;
      if (addr_i == ADDR_W'(OFS_MASK))   mask_q   <= wdata_i;
      if (addr_i == ADDR_W'(OFS_KIND_L)) kind_l_q <= wdata_i;
      if (addr_i == ADDR_W'(OFS_KIND_H)) kind_h_q <= wdata_i;
    end
  end

  assign clr_o = (we_i && addr_i == ADDR_W'(OFS_EVT)) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_DIR):    rdata_o = dir_q;
      ADDR_W'(OFS_DOUT):   rdata_o = dout_q;
      ADDR_W'(OFS_PIN):    rdata_o = pin_s_i;
      ADDR_W'(OFS_EVT):    rdata_o = evt_i;
      ADDR_W'(OFS_MASK):   rdata_o = mask_q;
      ADDR_W'(OFS_KIND_L): rdata_o = kind_l_q;
      ADDR_W'(OFS_KIND_H): rdata_o = kind_h_q;
      default:             rdata_o = '0;
    endcase
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFS_MASK)) |=> $stable(mask_q)); // R2
  AST_KIND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(kind_l_q) && $stable(kind_h_q))); // R2

  assign dir_o    = dir_q;
  assign dout_o   = dout_q;
  assign mask_o   = mask_q;
  assign kind_l_o = kind_l_q;
  assign kind_h_o = kind_h_q;
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl import gpio_evt_pkg::*; #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [NPIN-1:0]   reg_wdata_i,
  output logic [NPIN-1:0]   reg_rdata_o,
  input  logic [NPIN-1:0]   gpio_i,
  output logic [NPIN-1:0]   gpio_o,
  output logic [NPIN-1:0]   gpio_oe_o,
  output logic              irq_o
);
  localparam int unsigned HALF = NPIN / 2;

  logic      [NPIN-1:0] pin_s, evt, mask, kind_l, kind_h, clr;
  evt_kind_e [NPIN-1:0] kind;

  gpio_evt_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_s)
  );

  gpio_evt_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .evt_i   (evt),
    .pin_s_i (pin_s),
    .dir_o   (gpio_oe_o),
    .dout_o  (gpio_o),
    .mask_o  (mask),
    .kind_l_o(kind_l),
    .kind_h_o(kind_h),
    .clr_o   (clr)
  );

  // fields packed top-down: lowest pin of each half in the top bits
  for (genvar p = 0; p < NPIN; p++) begin : g_kind
    if (p < HALF) begin : g_lo
      assign kind[p] = evt_kind_e'(kind_l[(HALF-1-p)*2 +: 2]);
    end else begin : g_hi
      assign kind[p] = evt_kind_e'(kind_h[(NPIN-1-p)*2 +: 2]);
    end
  end

  gpio_evt_detect #(.NPIN(NPIN)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pin_s),
    .kind_i (kind),
    .clr_i  (clr),
    .evt_o  (evt)
  );

  assign irq_o = |(evt & mask);

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R10
  AST_IRQ_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt == '0) |-> !irq_o); // R10
endmodule

// File: tb/sim_gpio_evt_ctrl.sv
module sim_gpio_evt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, gpio_o, gpio_oe;
  logic [31:0] gpio = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  gpio_evt_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gpio_i(gpio),
    .gpio_o(gpio_o), .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {pin[4:0], kind[1:0], level before, level after, event expected}
  localparam logic [9:0] VEC [0:10] = '{
    {5'd0,  2'b00, 1'b0, 1'b1, 1'b1},
    {5'd0,  2'b00, 1'b1, 1'b0, 1'b1},
    {5'd17, 2'b00, 1'b1, 1'b0, 1'b1},
    {5'd5,  2'b01, 1'b0, 1'b1, 1'b1},
    {5'd5,  2'b01, 1'b1, 1'b0, 1'b0},
    {5'd15, 2'b01, 1'b0, 1'b1, 1'b1},
    {5'd20, 2'b10, 1'b1, 1'b0, 1'b1},
    {5'd20, 2'b10, 1'b0, 1'b1, 1'b0},
    {5'd16, 2'b10, 1'b1, 1'b0, 1'b1},
    {5'd31, 2'b11, 1'b1, 1'b0, 1'b1},
    {5'd31, 2'b11, 1'b1, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(8'(a), v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 oe", gpio_oe, 32'h0);
    chk("R1 out", gpio_o, 32'h0);

    // R2 readback
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'h1234_5678);
    wr(8'h10, 32'h8000_0001);
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h18, 32'h0BAD_F00D);
    rd(8'h00, v); chk("R2 dir", v, 32'hA5A5_0F0F);
    rd(8'h04, v); chk("R2 dout", v, 32'h1234_5678);
    rd(8'h10, v); chk("R2 mask", v, 32'h8000_0001);
    rd(8'h14, v); chk("R2 kind lo", v, 32'hDEAD_BEEF);
    rd(8'h18, v); chk("R2 kind hi", v, 32'h0BAD_F00D);
    rd(8'h1C, v); chk("R2 unmapped", v, 32'h0);
    chk("R2 gpio_oe_o", gpio_oe, 32'hA5A5_0F0F);
    chk("R2 gpio_o", gpio_o, 32'h1234_5678);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0);

    // R3 synchroniser latency
    gpio = 32'h0003_0C00;
    tick(1); rd(8'h08, v); chk("R3 after 1 edge", v, 32'h0);
    tick(1); rd(8'h08, v); chk("R3 after 2 edges", v, 32'h0003_0C00);
    gpio = 32'h0;
    tick(4);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R8 clear all", v, 32'h0);

    // R4..R7 vector walk
    foreach (VEC[i]) begin
      logic [4:0]  pin;
      logic [1:0]  kd;
      logic [31:0] fld, exp;
      pin = VEC[i][9:5];
      kd  = VEC[i][4:3];
      fld = 32'(kd) << ((15 - (pin % 16)) * 2);
      gpio = '0;
      tick(4);
      wr(8'h14, pin < 16 ? fld : 32'h0);
      wr(8'h18, pin < 16 ? 32'h0 : fld);
      gpio[pin] = VEC[i][2];
      tick(4);
      wr(8'h0C, 32'hFFFF_FFFF);
      gpio[pin] = VEC[i][1];
      tick(4);
      rd(8'h0C, v);
      exp = VEC[i][0] ? (32'h1 << pin) : 32'h0;
      case (kd)
        2'b00:   chk($sformatf("R4 R5 pin %0d", pin), v, exp);
        2'b11:   chk($sformatf("R4 R7 pin %0d", pin), v, exp);
        default: chk($sformatf("R4 R6 pin %0d", pin), v, exp);
      endcase
    end
    gpio = '0;
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0);
    tick(4);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R8 write-one-to-clear, zero ignored
    gpio[3] = 1'b1; gpio[9] = 1'b1;
    tick(4);
    rd(8'h0C, v); chk("R8 events set", v, 32'h0000_0208);
    wr(8'h0C, 32'h0);
    rd(8'h0C, v); chk("R8 write 0 ignored", v, 32'h0000_0208);
    wr(8'h0C, 32'h0000_0008);
    rd(8'h0C, v); chk("R8 selective clear", v, 32'h0000_0200);

    // R10 masking
    wr(8'h0C, 32'hFFFF_FFFF);
    gpio[9] = 1'b0;
    tick(4);
    wr(8'h0C, 32'hFFFF_FFFF);
    gpio[3] = 1'b0;
    tick(4);
    rd(8'h0C, v); chk("R10 setup", v, 32'h0000_0008);
    chk("R10 mask zero", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h0000_0010);
    chk("R10 other bit", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h0000_0008);
    chk("R10 matching bit", {31'h0, irq}, 32'h1);
    wr(8'h0C, 32'h0000_0008);
    chk("R10 after clear", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h0);

    // R11 latency: third edge
    gpio[3] = 1'b1;
    tick(2); rd(8'h0C, v); chk("R11 not before 3rd edge", v, 32'h0);
    tick(1); rd(8'h0C, v); chk("R11 at 3rd edge", v, 32'h0000_0008);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R9 event beats same-cycle clear
    gpio[12] = 1'b1;
    tick(4);
    wr(8'h0C, 32'hFFFF_FFFF);
    gpio[12] = 1'b0;
    tick(4);
    gpio[7] = 1'b1;
    tick(2);
    wr(8'h0C, 32'h0000_1080);
    rd(8'h0C, v); chk("R9 event wins clear", v, 32'h0000_0080);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R7 low level holds against clear
    wr(8'h14, 32'h3 << 26);
    tick(2);
    wr(8'h0C, 32'h0000_0004);
    rd(8'h0C, v); chk("R7 held while low", v, 32'h0000_0004);
    gpio[2] = 1'b1;
    tick(4);
    wr(8'h0C, 32'h0000_0004);
    rd(8'h0C, v); chk("R7 clears once high", v, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule